// File: doc/BRIEF.md
# Sample Stream Transmit Sequencer

This block sits between a converter that delivers 16-bit results and a byte-wide serial transmitter. After a start command it sends a short ASCII header. It then forwards each conversion result as two raw binary bytes, high byte first. Once the programmed number of samples has gone out, it closes the run with a fixed trailer. Raw binary keeps the link throughput at one byte per byte of data, where an ASCII hex form would need two characters for every byte.

Results arrive on a one-cycle strobe and are held in a single slot until both of their bytes have been accepted by the transmitter. A result that arrives while the slot still holds an unsent sample is dropped, and a sticky error flag is raised. The sample count is loaded from a 16-bit value that is one less than the number of samples wanted. The count is decremented after each sample, and the data phase ends when it wraps below zero.

Top module: `sample_tx_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and tx_valid_o are all 0. While idle, tx_valid_o stays 0.
- R2: A start_i pulse seen while idle sets busy_o in the next cycle, clears err_o and loads count_i. A start_i pulse seen while busy has no effect on the run in progress.
- R3: The first bytes of every run are the 9-byte header 0x0D 0x0A 0x53 0x43 0x41 0x4E 0x3E 0x0D 0x0A. The header ends at a zero entry in its table, and that zero byte is never sent.
- R4: Each sample is sent as two bytes: bits 15:8 first, then bits 7:0.
- R5: A run sends exactly count_i + 1 samples, with count_i taken at the start that was accepted.
- R6: After the last sample, the trailer is sent: eight bytes of 0xFF, then 0x0D, then 0x0A.
- R7: A byte is transferred in a cycle where tx_valid_o and tx_ready_i are both 1. While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o and tx_data_o keep their values in the next cycle.
- R8: A result strobe that arrives while a held sample still has its low byte unsent is dropped and sets err_o. A strobe in the same cycle as the held sample's low-byte transfer is accepted, except on the last sample.
- R9: err_o stays 1 until the next start that is accepted.
- R10: Result strobes during idle or during the trailer are ignored. They are not held for a later run.
- R11: In the cycle after the last trailer byte is transferred, busy_o is 0 and done_o is 1. done_o lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a run (taken only when idle) |
| count_i | input | COUNT_W | Samples in the run, minus one |
| res_valid_i | input | 1 | One-cycle strobe: a conversion result is ready |
| res_data_i | input | 16 | Conversion result |
| tx_ready_i | input | 1 | Transmitter can take a byte this cycle |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| err_o | output | 1 | Sticky overrun flag |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong state or index in the sequencer shows up in the byte stream within one or two transfers. It appears as a header or trailer byte out of place, a swapped pair of bytes, or a run that is one sample too long or too short. A faulty holding slot shows up differently: a dropped or repeated sample in the stream, a stale value from idle appearing at the start of the next run, or err_o rising in the cycle after a legal strobe. The done pulse and busy fall are checked in the exact cycle after the last trailer byte.

// File: rtl/stx_pkg.sv
// Shared types and constants for the sample stream transmit sequencer.
// Assumes an 8-bit transmit byte and a 16-bit conversion result.
package stx_pkg;

    localparam int BYTE_W     = 8;
    localparam int SAMPLE_W   = 2 * BYTE_W;
    localparam int HDR_LEN    = 10;                 // 9 bytes plus zero terminator
    localparam int HDR_IDX_W  = $clog2(HDR_LEN);
    localparam logic [BYTE_W-1:0] CH_CR   = 8'h0D;
    localparam logic [BYTE_W-1:0] CH_LF   = 8'h0A;
    localparam logic [BYTE_W-1:0] CH_FILL = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WAIT,
        ST_HI,
        ST_LO,
        ST_TRL
    } stx_state_t;

    // Header table: CR LF "SCAN>" CR LF, then a zero terminator
    function automatic logic [BYTE_W-1:0] hdr_char(input int idx);
        case (idx)
            0:       return CH_CR;
            1:       return CH_LF;
            2:       return 8'h53;
            3:       return 8'h43;
            4:       return 8'h41;
            5:       return 8'h4E;
            6:       return 8'h3E;
            7:       return CH_CR;
            8:       return CH_LF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/stx_hdr_rom.sv
// Constant header table.
// Returns the header byte at idx_i; any index past the text reads zero,
// and the controller treats zero as the end of the header.
module stx_hdr_rom #(
    parameter int IDX_W = stx_pkg::HDR_IDX_W
) (
    input  logic [IDX_W-1:0]          idx_i,
    output logic [stx_pkg::BYTE_W-1:0] byte_o
);
    // Table lookup
    always_comb begin
        byte_o = stx_pkg::hdr_char(32'(idx_i));
    end
endmodule

// File: rtl/stx_hold.sv
// Single-entry result holding slot with overrun detection.
// Takes a result when armed and either empty or being released in the same
// cycle. A strobe that finds the slot full and not releasing is dropped and
// raises the sticky error, which only clr_i (an accepted start) clears.
module stx_hold (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          arm_i,
    input  logic                          strobe_i,
    input  logic [stx_pkg::SAMPLE_W-1:0]  data_i,
    input  logic                          release_i,
    output logic                          full_o,
    output logic [stx_pkg::SAMPLE_W-1:0]  data_o,
    output logic                          err_o
);
    logic                         full_q;
    logic                         err_q;
    logic [stx_pkg::SAMPLE_W-1:0] data_q;
    logic                         take;

    // Slot can take a new result
    assign take = arm_i && strobe_i && (!full_q || release_i);

    // Slot occupancy and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (take)
                full_q <= 1'b1;
            else if (release_i)
                full_q <= 1'b0;
            if (clr_i)
                err_q <= 1'b0;
            else if (arm_i && strobe_i && full_q && !release_i)
                err_q <= 1'b1;
        end
    end

    // Result storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (take)
            data_q <= data_i;
    end

    assign full_o = full_q;
    assign data_o = data_q;
    assign err_o  = err_q;
endmodule

// File: rtl/stx_ctrl.sv
// Run sequencer: header, data pairs, trailer.
// Assumes the holding slot reports full_i with stable data while a sample is
// pending. Counts samples down from the loaded value; the run's data phase
// ends after the sample sent while the count is zero.
module stx_ctrl #(
    parameter int COUNT_W = 16,
    parameter int FILL_N  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [COUNT_W-1:0]            count_i,
    input  logic                          full_i,
    input  logic [stx_pkg::SAMPLE_W-1:0]  held_i,
    input  logic                          tx_ready_i,
    input  logic [stx_pkg::BYTE_W-1:0]    hdr_byte_i,
    output logic [stx_pkg::HDR_IDX_W-1:0] hdr_idx_o,
    output logic [stx_pkg::BYTE_W-1:0]    tx_data_o,
    output logic                          tx_valid_o,
    output logic                          release_o,
    output logic                          arm_o,
    output logic                          start_ok_o,
    output logic                          busy_o,
    output logic                          done_o
);
    import stx_pkg::*;

    localparam int TRL_LEN   = FILL_N + 2;
    localparam int TRL_IDX_W = $clog2(TRL_LEN);
    localparam logic [TRL_IDX_W-1:0] TRL_LAST = TRL_IDX_W'(TRL_LEN - 1);
    localparam logic [TRL_IDX_W-1:0] TRL_CR   = TRL_IDX_W'(FILL_N);

    stx_state_t             state_q;
    logic [COUNT_W-1:0]     cnt_q;
    logic [HDR_IDX_W-1:0]   hidx_q;
    logic [TRL_IDX_W-1:0]   tidx_q;
    logic                   done_q;
    logic                   last_smp;
    logic [BYTE_W-1:0]      trl_byte;

    // Final sample of the run is the one sent at count zero
    assign last_smp = (cnt_q == '0);

    // Trailer byte: fill bytes, then CR, then LF
    always_comb begin
        if (tidx_q < TRL_CR)
            trl_byte = CH_FILL;
        else if (tidx_q == TRL_CR)
            trl_byte = CH_CR;
        else
            trl_byte = CH_LF;
    end

    // Output byte and valid selected by state
    always_comb begin
        tx_valid_o = 1'b0;
        tx_data_o  = '0;
        case (state_q)
            ST_HDR: begin
                tx_data_o  = hdr_byte_i;
                tx_valid_o = (hdr_byte_i != '0);
            end
            ST_HI: begin
                tx_data_o  = held_i[SAMPLE_W-1:BYTE_W];
                tx_valid_o = 1'b1;
            end
            ST_LO: begin
                tx_data_o  = held_i[BYTE_W-1:0];
                tx_valid_o = 1'b1;
            end
            ST_TRL: begin
                tx_data_o  = trl_byte;
                tx_valid_o = 1'b1;
            end
            default: begin
                tx_valid_o = 1'b0;
                tx_data_o  = '0;
            end
        endcase
    end

    // State, counters and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hidx_q  <= '0;
            tidx_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_HDR;
                        cnt_q   <= count_i;
                        hidx_q  <= '0;
                    end
                end
                ST_HDR: begin
                    if (hdr_byte_i == '0)
                        state_q <= ST_WAIT;
                    else if (tx_ready_i)
                        hidx_q <= hidx_q + 1'b1;
                end
                ST_WAIT: begin
                    if (full_i)
                        state_q <= ST_HI;
                end
                ST_HI: begin
                    if (tx_ready_i)
                        state_q <= ST_LO;
                end
                ST_LO: begin
                    if (tx_ready_i) begin
                        cnt_q <= cnt_q - 1'b1;
                        if (last_smp) begin
                            state_q <= ST_TRL;
                            tidx_q  <= '0;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_TRL: begin
                    if (tx_ready_i) begin
                        if (tidx_q == TRL_LAST) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            tidx_q <= tidx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Low byte accepted: held sample is fully sent
    assign release_o  = (state_q == ST_LO) && tx_ready_i;
    // Strobes taken during header and data, never after the last sample
    assign arm_o      = (state_q == ST_HDR) || (state_q == ST_WAIT) ||
                        (state_q == ST_HI)  || ((state_q == ST_LO) && !last_smp);
    assign start_ok_o = (state_q == ST_IDLE) && start_i;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign hdr_idx_o  = hidx_q;
endmodule

// File: rtl/sample_tx_seq.sv
// Sample stream transmit sequencer, top level.
// Frames a run of 16-bit results as header, raw byte pairs (high first) and
// trailer on a valid/ready byte interface. Assumes one-cycle result strobes.
module sample_tx_seq #(
    parameter int COUNT_W = 16,
    parameter int FILL_N  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic               res_valid_i,
    input  logic [15:0]        res_data_i,
    input  logic               tx_ready_i,
    output logic [7:0]         tx_data_o,
    output logic               tx_valid_o,
    output logic               err_o,
    output logic               busy_o,
    output logic               done_o
);
    import stx_pkg::*;

    logic [HDR_IDX_W-1:0] hdr_idx;
    logic [BYTE_W-1:0]    hdr_byte;
    logic                 full;
    logic [SAMPLE_W-1:0]  held;
    logic                 rel;
    logic                 arm;
    logic                 start_ok;

    stx_hdr_rom #(.IDX_W(HDR_IDX_W)) u_rom (
        .idx_i  (hdr_idx),
        .byte_o (hdr_byte)
    );

    stx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_ok),
        .arm_i     (arm),
        .strobe_i  (res_valid_i),
        .data_i    (res_data_i),
        .release_i (rel),
        .full_o    (full),
        .data_o    (held),
        .err_o     (err_o)
    );

    stx_ctrl #(.COUNT_W(COUNT_W), .FILL_N(FILL_N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .full_i     (full),
        .held_i     (held),
        .tx_ready_i (tx_ready_i),
        .hdr_byte_i (hdr_byte),
        .hdr_idx_o  (hdr_idx),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .release_o  (rel),
        .arm_o      (arm),
        .start_ok_o (start_ok),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );
endmodule

// File: rtl/stx_sva.sv
// Port-level protocol checks for the sequencer, bound to the top module.
module stx_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       tx_ready_i,
    input logic [7:0] tx_data_o,
    input logic       tx_valid_o,
    input logic       err_o,
    input logic       busy_o,
    input logic       done_o
);
    // R1: no transmit traffic while idle
    assert_valid_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> busy_o);

    // R7: a stalled byte holds
    assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R2: accepted start clears the error and begins a run
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !err_o));

    // R9: error stays set until an accepted start
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(start_i && !busy_o)) |=> err_o);

    // R11: done is a single-cycle pulse
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: done comes as busy falls
    assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind sample_tx_seq stx_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .err_o      (err_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_sample_tx_seq.sv
`timescale 1ns/1ps
module tb_sample_tx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] count_i = '0;
    logic        res_valid_i = 1'b0;
    logic [15:0] res_data_i = '0;
    logic        tx_ready_i = 1'b1;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        err_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit throttle = 1'b0;
    bit finished = 1'b0;
    logic [3:0] rdy_ph = '0;
    logic [7:0] got[$];
    logic [7:0] expq[$];

    localparam int HB = 9;

    always #2.5 clk = ~clk;

    sample_tx_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .res_valid_i(res_valid_i), .res_data_i(res_data_i),
        .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
        .err_o(err_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Receiver: always ready, or ready one cycle in four
    always @(posedge clk) begin
        #1;
        rdy_ph = rdy_ph + 1'b1;
        tx_ready_i = throttle ? (rdy_ph[1:0] == 2'b11) : 1'b1;
    end

    // Monitor: byte transferred at the coming edge; done pulses
    always @(negedge clk) begin
        if (rst_n && tx_valid_o && tx_ready_i) got.push_back(tx_data_o);
        if (rst_n && done_o) done_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] n);
        @(posedge clk); #1;
        start_i = 1'b1; count_i = n;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic pulse_res(input logic [15:0] d);
        @(posedge clk); #1;
        res_valid_i = 1'b1; res_data_i = d;
        @(posedge clk); #1;
        res_valid_i = 1'b0;
    endtask

    task automatic wait_bytes(input int n);
        while (got.size() < n) @(negedge clk);
    endtask

    task automatic exp_header();
        expq.push_back(8'h0D); expq.push_back(8'h0A);
        expq.push_back(8'h53); expq.push_back(8'h43); expq.push_back(8'h41);
        expq.push_back(8'h4E); expq.push_back(8'h3E);
        expq.push_back(8'h0D); expq.push_back(8'h0A);
    endtask

    task automatic exp_sample(input logic [15:0] d);
        expq.push_back(d[15:8]);
        expq.push_back(d[7:0]);
    endtask

    task automatic exp_trailer();
        for (int i = 0; i < 8; i++) expq.push_back(8'hFF);
        expq.push_back(8'h0D); expq.push_back(8'h0A);
    endtask

    // R11: wait for done, then check busy low and single-cycle pulse
    task automatic wait_done();
        int d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
        chk("R11 busy low with done", 32'(busy_o), 0);
        @(negedge clk);
        chk("R11 done one cycle", 32'(done_o), 0);
    endtask

    task automatic cmp_stream(input string dreq);
        chk({dreq, " stream length"}, 32'(got.size()), 32'(expq.size()));
        for (int i = 0; i < expq.size() && i < got.size(); i++) begin
            if (i < HB)                     chk("R3 header byte", 32'(got[i]), 32'(expq[i]));
            else if (i >= expq.size() - 10) chk("R6 trailer byte", 32'(got[i]), 32'(expq[i]));
            else                            chk({dreq, " data byte"}, 32'(got[i]), 32'(expq[i]));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy_o), 0);
        chk("R1 valid after reset", 32'(tx_valid_o), 0);
        chk("R1 err after reset", 32'(err_o), 0);
        chk("R1 done after reset", 32'(done_o), 0);
    endtask

    // R4 R5: plain run of n+1 samples
    task automatic t_basic(input logic [15:0] n, input bit thr);
        throttle = thr;
        got.delete(); expq.delete();
        exp_header();
        do_start(n);
        @(negedge clk);
        chk("R2 busy after start", 32'(busy_o), 1);
        for (int k = 0; k <= int'(n); k++) begin
            logic [15:0] d = 16'hA5C3 + 16'(k) * 16'h1357;
            wait_bytes(HB + 2 * k);
            pulse_res(d);
            exp_sample(d);
        end
        exp_trailer();
        wait_done();
        cmp_stream(thr ? "R7 R4 R5 throttled" : "R4 R5");
        chk("R8 no error on paced samples", 32'(err_o), 0);
        throttle = 1'b0;
    endtask

    // R2: a start during a run is ignored
    task automatic t_restart_ignored();
        throttle = 1'b1;
        got.delete(); expq.delete();
        exp_header();
        do_start(16'd1);
        repeat (3) @(posedge clk);
        do_start(16'd5);
        for (int k = 0; k < 2; k++) begin
            logic [15:0] d = 16'h0F1E + 16'(k) * 16'h2222;
            wait_bytes(HB + 2 * k);
            pulse_res(d);
            exp_sample(d);
        end
        exp_trailer();
        wait_done();
        cmp_stream("R2 R5 restart ignored");
        throttle = 1'b0;
    endtask

    // R8 R9: overrun drops the second result, flag sticks past done
    task automatic t_overrun();
        got.delete(); expq.delete();
        exp_header();
        do_start(16'd1);
        pulse_res(16'h1234);
        pulse_res(16'hBEEF);
        @(negedge clk);
        chk("R8 err after overrun", 32'(err_o), 1);
        exp_sample(16'h1234);
        wait_bytes(HB + 2);
        pulse_res(16'h5678);
        exp_sample(16'h5678);
        exp_trailer();
        wait_done();
        cmp_stream("R8 dropped sample");
        chk("R9 err sticky after done", 32'(err_o), 1);
    endtask

    // R8 R9: strobe in the low-byte transfer cycle is accepted
    task automatic t_same_cycle();
        got.delete(); expq.delete();
        exp_header();
        do_start(16'd1);
        @(negedge clk);
        chk("R9 err cleared by start", 32'(err_o), 0);
        pulse_res(16'h2468);
        exp_sample(16'h2468);
        wait_bytes(HB + 1);
        pulse_res(16'h9ACE);
        exp_sample(16'h9ACE);
        exp_trailer();
        wait_done();
        cmp_stream("R8 same-cycle accept");
        chk("R8 no err on same-cycle strobe", 32'(err_o), 0);
    endtask

    // R10: strobes in idle and in the trailer are not held
    task automatic t_ignored();
        got.delete(); expq.delete();
        pulse_res(16'hDEAD);
        @(negedge clk);
        chk("R10 idle no valid", 32'(tx_valid_o), 0);
        chk("R10 idle not busy", 32'(busy_o), 0);
        exp_header();
        do_start(16'd0);
        wait_bytes(HB);
        pulse_res(16'h4321);
        exp_sample(16'h4321);
        wait_bytes(HB + 3);
        pulse_res(16'hCAFE);
        exp_trailer();
        wait_done();
        cmp_stream("R10 first run");
        chk("R10 no err from ignored strobes", 32'(err_o), 0);
        got.delete(); expq.delete();
        exp_header();
        do_start(16'd0);
        wait_bytes(HB);
        pulse_res(16'h7777);
        exp_sample(16'h7777);
        exp_trailer();
        wait_done();
        cmp_stream("R10 stale value not held");
        chk("R10 no err next run", 32'(err_o), 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        t_reset();
        t_basic(16'd2, 1'b0);
        t_basic(16'd0, 1'b1);
        t_restart_ignored();
        t_overrun();
        t_same_cycle();
        t_ignored();
        t_basic(16'd20, 1'b0);
        finish_up();
    end
endmodule